// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on a CPU-side 32-bit I/O bus. It turns accesses to two fixed ports into single configuration transactions on a downstream configuration bus. Software first writes a selector into the address port. The selector holds an enable bit and the target bus, device and function, plus a dword-aligned register offset. A later full-width access to the data port becomes exactly one 32-bit configuration read or write to that target.

The CPU access stalls until the downstream side answers. It also ends if a fixed timeout runs out. A read that no function claims returns all ones, so enumeration software can find empty slots. When the enable bit is clear, no downstream cycle is issued. Accesses that are narrower than 32 bits, or that fall outside the two ports, have no effect, and reads of them return all ones.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address port reads 0 and no downstream request has been issued.
- R2: A full 32-bit write to the address port (I/O 0xCF8) is latched. Reading the port returns the written value with bits 30:24 and 1:0 forced to 0.
- R3: A full read of the data port (I/O 0xCFC) with address-port bit 31 set issues one read request. The request carries bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register offset = bits 7:2 with its two low bits 0. The response data is returned to the CPU.
- R4: A full write of the data port with the enable bit set issues one write request carrying the CPU write data.
- R5: With address-port bit 31 clear, a data-port access issues no request. Reads return 0xFFFFFFFF and writes are dropped.
- R6: A response with the hit flag low completes the read with 0xFFFFFFFF.
- R7: If no response arrives within TIMEOUT cycles, the access completes and a read returns 0xFFFFFFFF.
- R8: An access whose byte enables are not all four set (io_be != 4'hF) changes no state and issues no request. A read of this kind returns 0xFFFFFFFF.
- R9: Accesses to any I/O address other than the two ports change no state and read 0xFFFFFFFF.
- R10: At most one request is in flight. io_ready stays low until the response (or timeout), and the address port cannot change while a cycle is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid | input | 1 | CPU access request, held until io_ready |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O address |
| io_be | input | 4 | Byte enables; 4'hF = full access |
| io_wdata | input | 32 | CPU write data |
| io_ready | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with io_ready |
| cfg_req_valid | output | 1 | One-cycle downstream request pulse |
| cfg_req_write | output | 1 | Downstream direction |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_reg | output | 8 | Byte offset of the dword, low bits 0 |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_rsp_valid | input | 1 | Downstream response strobe |
| cfg_rsp_hit | input | 1 | 1 = a function claimed the cycle |
| cfg_rsp_rdata | input | 32 | Downstream read data |

## Verification
The timeout path is the hardest case to reach from the ports, because any attached target normally answers. The bench's responder model has a silent mode that swallows the request. This forces the full TIMEOUT wait, and the bench then checks that the access ends no sooner than that and returns all ones. A second mode adds a long response delay. It shows that the CPU stays stalled and that only one request pulse is issued.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int IO_AW     = 16,
  parameter int ADDR_PORT = 'hCF8,
  parameter int DATA_PORT = 'hCFC,
  parameter int TIMEOUT   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic             io_ready,
  output logic [31:0]      io_rdata,
  output logic             cfg_req_valid,
  output logic             cfg_req_write,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_fn,
  output logic [7:0]       cfg_reg,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_rsp_valid,
  input  logic             cfg_rsp_hit,
  input  logic [31:0]      cfg_rsp_rdata
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);
  localparam logic [31:0] SEL_MASK = 32'h80FF_FFFC;
  localparam logic [31:0] ONES = '1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_t;

  st_t st;
  logic [31:0] sel_q, rdata_q, wdata_q;
  logic        req_q, wr_q;
  logic [TW-1:0] timer;

  wire full   = io_be == 4'hF;
  wire at_sel = io_addr == IO_AW'(ADDR_PORT);
  wire at_dat = io_addr == IO_AW'(DATA_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sel_q <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      req_q <= 1'b0;
      wr_q <= 1'b0;
      timer <= '0;
    end else begin
      case (st)
        S_IDLE: if (io_valid) begin
          if (at_sel && full) begin
            if (io_write) sel_q <= io_wdata & SEL_MASK;
            rdata_q <= sel_q;
            st <= S_DONE;
          end else if (at_dat && full && sel_q[31]) begin
            req_q <= 1'b1;
            wr_q <= io_write;
            wdata_q <= io_wdata;
            timer <= '0;
            st <= S_WAIT;
          end else begin
            rdata_q <= ONES;
            st <= S_DONE;
          end
        end
        S_WAIT: begin
          req_q <= 1'b0;
          if (cfg_rsp_valid) begin
            rdata_q <= cfg_rsp_hit ? cfg_rsp_rdata : ONES;
            st <= S_DONE;
          end else if (timer == TLAST) begin
            rdata_q <= ONES;
            st <= S_DONE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign io_ready      = st == S_DONE;
  assign io_rdata      = rdata_q;
  assign cfg_req_valid = req_q;
  assign cfg_req_write = wr_q;
  assign cfg_bus       = sel_q[23:16];
  assign cfg_dev       = sel_q[15:11];
  assign cfg_fn        = sel_q[10:8];
  assign cfg_reg       = {sel_q[7:2], 2'b00};
  assign cfg_wdata     = wdata_q;

  a_r10_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |=> !cfg_req_valid);
  a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(sel_q));
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |=> !io_ready);
  a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> sel_q[31]);
  a_r7_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (timer <= TLAST));
  a_r2_sel_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sel_q) |-> (sel_q[30:24] == 7'd0 && sel_q[1:0] == 2'd0));
endmodule

// File: tb/cfg_port_bridge_bench.sv
module cfg_port_bridge_bench;
  localparam int TIMEOUT = 64;
  localparam logic [15:0] PA = 16'hCF8;
  localparam logic [15:0] PD = 16'hCFC;

  logic clk = 0, rst_n = 0;
  logic io_valid = 0, io_write = 0;
  logic [15:0] io_addr = '0;
  logic [3:0] io_be = '0;
  logic [31:0] io_wdata = '0;
  logic io_ready;
  logic [31:0] io_rdata;
  logic cfg_req_valid, cfg_req_write;
  logic [7:0] cfg_bus, cfg_reg;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn;
  logic [31:0] cfg_wdata;
  logic cfg_rsp_valid = 0, cfg_rsp_hit = 0;
  logic [31:0] cfg_rsp_rdata = '0;

  int checks = 0, failures = 0;
  int req_count = 0;
  int rsp_mode = 0;
  int rsp_delay = 1;
  logic last_wr;
  logic [7:0] last_bus, last_reg;
  logic [4:0] last_dev;
  logic [2:0] last_fn;
  logic [31:0] last_wdata;

  always #2 clk = ~clk;

  cfg_port_bridge #(.TIMEOUT(TIMEOUT)) u_cfg_port_bridge (
    .clk, .rst_n, .io_valid, .io_write, .io_addr, .io_be, .io_wdata,
    .io_ready, .io_rdata, .cfg_req_valid, .cfg_req_write, .cfg_bus,
    .cfg_dev, .cfg_fn, .cfg_reg, .cfg_wdata, .cfg_rsp_valid,
    .cfg_rsp_hit, .cfg_rsp_rdata);

  initial begin
    forever begin
      @(negedge clk);
      if (cfg_req_valid) begin
        req_count++;
        last_wr = cfg_req_write; last_bus = cfg_bus; last_dev = cfg_dev;
        last_fn = cfg_fn; last_reg = cfg_reg; last_wdata = cfg_wdata;
        if (rsp_mode != 2) begin
          repeat (rsp_delay - 1) @(negedge clk);
          cfg_rsp_valid = 1;
          cfg_rsp_hit = (rsp_mode == 0);
          cfg_rsp_rdata = {cfg_bus, 3'b0, cfg_dev, 5'b0, cfg_fn, cfg_reg};
          @(negedge clk);
          cfg_rsp_valid = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input logic [15:0] a, input logic [3:0] be,
                      input logic [31:0] d, output logic [31:0] q, output int cyc);
    @(negedge clk);
    io_valid = 1; io_write = w; io_addr = a; io_be = be; io_wdata = d;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (io_ready) break;
    end
    q = io_rdata;
    io_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] q; int c;
    xfer(0, PA, 4'hF, 0, q, c);
    check(q == 0, "R1 addr port after reset", q, 0);
    check(req_count == 0, "R1 no request after reset", req_count, 0);
  endtask

  task automatic t_sel;
    logic [31:0] q; int c;
    xfer(1, PA, 4'hF, 32'hFFFF_FFFF, q, c);
    xfer(0, PA, 4'hF, 0, q, c);
    check(q == 32'h80FF_FFFC, "R2 readback mask", q, 32'h80FF_FFFC);
    xfer(1, PA, 4'hF, 32'h1234_5677, q, c);
    xfer(0, PA, 4'hF, 0, q, c);
    check(q == 32'h0034_5674, "R2 readback value", q, 32'h0034_5674);
  endtask

  task automatic t_read;
    logic [31:0] q, e; int c, n;
    xfer(1, PA, 4'hF, 32'h8003_1A47, q, c);
    n = req_count;
    xfer(0, PD, 4'hF, 0, q, c);
    e = {8'h03, 3'b0, 5'd3, 5'b0, 3'd2, 8'h44};
    check(q == e, "R3 read data", q, e);
    check(req_count == n + 1, "R3 one request", req_count, n + 1);
    check(last_wr == 0 && last_bus == 3 && last_dev == 3 && last_fn == 2 && last_reg == 8'h44,
          "R3 request fields", {last_bus, 3'b0, last_dev, 5'b0, last_fn, last_reg}, e);
  endtask

  task automatic t_write;
    logic [31:0] q; int c, n;
    n = req_count;
    xfer(1, PD, 4'hF, 32'hDEAD_BEEF, q, c);
    check(req_count == n + 1 && last_wr == 1, "R4 write request", req_count, n + 1);
    check(last_wdata == 32'hDEAD_BEEF, "R4 write data", last_wdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_disabled;
    logic [31:0] q; int c, n;
    xfer(1, PA, 4'hF, 32'h0003_1A44, q, c);
    n = req_count;
    xfer(0, PD, 4'hF, 0, q, c);
    check(q == '1, "R5 disabled read", q, '1);
    xfer(1, PD, 4'hF, 32'h5555_5555, q, c);
    check(req_count == n, "R5 no request when disabled", req_count, n);
  endtask

  task automatic t_miss;
    logic [31:0] q; int c;
    xfer(1, PA, 4'hF, 32'h8000_0800, q, c);
    rsp_mode = 1;
    xfer(0, PD, 4'hF, 0, q, c);
    check(q == '1, "R6 miss returns ones", q, '1);
    rsp_mode = 0;
  endtask

  task automatic t_timeout;
    logic [31:0] q; int c;
    rsp_mode = 2;
    xfer(0, PD, 4'hF, 0, q, c);
    check(q == '1, "R7 timeout returns ones", q, '1);
    check(c >= TIMEOUT && c <= TIMEOUT + 4, "R7 timeout length", c, TIMEOUT);
    rsp_mode = 0;
  endtask

  task automatic t_partial;
    logic [31:0] q; int c, n;
    xfer(1, PA, 4'hF, 32'h8001_0010, q, c);
    n = req_count;
    xfer(1, PA, 4'h3, 32'h0000_0000, q, c);
    xfer(0, PA, 4'hF, 0, q, c);
    check(q == 32'h8001_0010, "R8 partial write ignored", q, 32'h8001_0010);
    xfer(0, PD, 4'h1, 0, q, c);
    check(q == '1, "R8 partial read ones", q, '1);
    xfer(1, PD, 4'h7, 32'h1, q, c);
    check(req_count == n, "R8 no request", req_count, n);
  endtask

  task automatic t_unmapped;
    logic [31:0] q; int c, n;
    n = req_count;
    xfer(1, 16'hCF4, 4'hF, 32'h0, q, c);
    xfer(0, PA, 4'hF, 0, q, c);
    check(q == 32'h8001_0010, "R9 other address no effect", q, 32'h8001_0010);
    xfer(0, 16'hCF0, 4'hF, 0, q, c);
    check(q == '1, "R9 other address reads ones", q, '1);
    check(req_count == n, "R9 no request", req_count, n);
  endtask

  task automatic t_latency;
    logic [31:0] q, e; int c, n;
    rsp_delay = 12;
    n = req_count;
    xfer(0, PD, 4'hF, 0, q, c);
    e = {8'h01, 3'b0, 5'd0, 5'b0, 3'd0, 8'h10};
    check(c >= 13, "R10 stall until response", c, 13);
    check(q == e, "R10 delayed data", q, e);
    check(req_count == n + 1, "R10 single request", req_count, n + 1);
    rsp_delay = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_sel;
    t_read;
    t_write;
    t_disabled;
    t_miss;
    t_read;
    t_timeout;
    t_partial;
    t_unmapped;
    t_latency;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule